// File: doc/BRIEF.md
# Paged Byte Memory Target on a Two-Wire Bus

This block is a two-wire bus target (SMBus/I2C electrical conventions) that serves a small byte-wide memory held in registers. The memory is divided into eight-byte pages. The block oversamples the clock and data lines with the system clock. It finds start and stop conditions and decodes the address, command and data phases. It drives the data line only as an open-drain pull-down enable.

A host reaches any byte in several ways. It can read from the internal pointer. It can load the pointer with a write frame that carries no data, then read after a repeated start. It can keep reading as long as it acknowledges. It can write one byte, or write several bytes in a burst.

Reads and writes advance the pointer in different ways:
- A read moves the pointer through the whole array and wraps back to byte zero after the last byte.
- A write moves the pointer only within its current page.

A write-protect input that is active high makes every write frame complete on the bus without changing any byte.

Top module: `smbt_eeprom_target`

## Requirements
- R1: After reset the target does not pull the data line low (`sda_oe_o` = 0), and every memory byte reads as 0x00.
- R2: The target acknowledges (pulls the data line low in the ninth clock) only an address byte whose upper seven bits equal parameter `DEV_ADDR`. Bit 0 of that byte set to 1 selects a read. For any other address the target leaves the line released and ignores the rest of the frame.
- R3: Each byte read moves the pointer to the next byte. After the last byte of the array it moves to byte 0.
- R4: Each byte written moves the pointer to the next offset of the same page. After offset 7 it moves to offset 0 of that page, and the page bits never change.
- R5: A read frame that sends no word address returns the byte at the pointer, and that pointer is one past the byte last read or written.
- R6: In a write frame, the first byte after the device address loads the pointer (its low `ADDR_W` bits). A repeated start and a read frame then return the byte at that address.
- R7: During a read, the target sends the next byte after every host acknowledge. After a host NACK it releases the line and sends nothing more.
- R8: Every further data byte in the same write frame is stored at the pointer, and the pointer then steps as in R4.
- R9: While `wp_i` is high, write frames are still acknowledged in full but leave every memory byte unchanged.
- R10: A start or stop condition in any state releases the line and restarts frame decoding. The pointer keeps its value, and a partly received byte is not stored.
- R11: The target changes `sda_oe_o` only while the sampled clock line is low, except to release the line on a start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sda_oe_o | output | 1 | 1 = pull the data line low |
| wp_i | input | 1 | Write protect, active high |

## Verification
The hardest case to reach is the boundary between two pointer rules. A page write has to run past offset 7 while starting away from the page start, and a read has to cross the top of the array. Both must then be observed through later reads, because the pointer itself is hidden.

Directed frames cover these cases:
- A burst write that starts at offset 5 of the last page and runs twelve bytes.
- A sequential read that starts two bytes below the end of the array.
- A frame cut off in mid-byte by a stop.

Random frames then mix writes, random reads and pointer reads of random lengths and addresses, with protection toggled now and then. Each result is compared against a bench model of the array and the pointer.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

    localparam int PAGE_BYTES = 8;
    localparam int PAGE_W     = $clog2(PAGE_BYTES);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } bus_state_e;

endpackage

// File: rtl/smbt_bus_sync.sv
module smbt_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_sync_q, sda_sync_q;
    logic              scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync_q <= '1;
            sda_sync_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sync_q <= {scl_sync_q[STAGES-2:0], scl_i};
            sda_sync_q <= {sda_sync_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_sync_q[STAGES-1];
            sda_prev_q <= sda_sync_q[STAGES-1];
        end
    end

    assign scl_s    = scl_sync_q[STAGES-1];
    assign sda_s    = sda_sync_q[STAGES-1];
    assign scl_rise = scl_s & ~scl_prev_q;
    assign scl_fall = ~scl_s & scl_prev_q;
    assign start_ev = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_ev  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/smbt_ptr_step.sv
module smbt_ptr_step #(
    parameter int ADDR_W = 5,
    parameter int PAGE_W = 3
) (
    input  logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] rd_next,
    output logic [ADDR_W-1:0] wr_next
);
    // Reads wrap over the whole array: natural modulo of the width.
    assign rd_next = ptr + ADDR_W'(1);

    generate
        if (PAGE_W < ADDR_W) begin : g_paged
            logic [PAGE_W-1:0] off_inc;
            assign off_inc = ptr[PAGE_W-1:0] + PAGE_W'(1);
            assign wr_next = {ptr[ADDR_W-1:PAGE_W], off_inc};
        end else begin : g_single
            assign wr_next = ptr + ADDR_W'(1);
        end
    endgenerate
endmodule

// File: rtl/smbt_regfile.sv
module smbt_regfile #(
    parameter int MEM_BYTES = 32,
    parameter int ADDR_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    logic [7:0] mem_q [MEM_BYTES];

    generate
        for (genvar i = 0; i < MEM_BYTES; i++) begin : g_byte
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem_q[i] <= 8'h00;
                else if (we && (addr == ADDR_W'(i)))
                    mem_q[i] <= wdata;
            end
        end
    endgenerate

    assign rdata = mem_q[addr];
endmodule

// File: rtl/smbt_eeprom_target.sv
module smbt_eeprom_target #(
    parameter logic [6:0] DEV_ADDR  = 7'h50,
    parameter int         MEM_BYTES = 32,
    parameter int         SYNC_STG  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    input  logic wp_i
);
    import smbt_pkg::*;

    localparam int ADDR_W = $clog2(MEM_BYTES);

    typedef struct packed {
        bus_state_e        state;
        logic [7:0]        shreg;
        logic [3:0]        cnt;
        logic              oe;
        logic              rw;
        logic              more;
        logic [ADDR_W-1:0] ptr;
    } regs_t;

    regs_t regs_d, regs_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [ADDR_W-1:0] rd_next, wr_next;
    logic [7:0] rdata;
    logic mem_we, rd_load;
    logic [ADDR_W-1:0] ptr_q;

    smbt_bus_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    smbt_ptr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step (
        .ptr(regs_q.ptr), .rd_next(rd_next), .wr_next(wr_next)
    );

    smbt_regfile #(.MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(regs_q.ptr),
        .wdata(regs_q.shreg), .rdata(rdata)
    );

    always_comb begin
        regs_d  = regs_q;
        mem_we  = 1'b0;
        rd_load = 1'b0;
        if (start_ev) begin
            regs_d.state = ST_DEV;
            regs_d.cnt   = '0;
            regs_d.oe    = 1'b0;
        end else if (stop_ev) begin
            regs_d.state = ST_IDLE;
            regs_d.cnt   = '0;
            regs_d.oe    = 1'b0;
        end else begin
            unique case (regs_q.state)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise && regs_q.cnt < 4'd8) begin
                        regs_d.shreg = {regs_q.shreg[6:0], sda_s};
                        regs_d.cnt   = regs_q.cnt + 4'd1;
                    end
                    if (scl_fall && regs_q.cnt == 4'd8) begin
                        regs_d.cnt = '0;
                        if (regs_q.state == ST_DEV) begin
                            if (regs_q.shreg[7:1] == DEV_ADDR) begin
                                regs_d.oe    = 1'b1;
                                regs_d.rw    = regs_q.shreg[0];
                                regs_d.state = ST_DEV_ACK;
                            end else begin
                                regs_d.state = ST_IDLE;
                            end
                        end else if (regs_q.state == ST_WADDR) begin
                            regs_d.ptr   = regs_q.shreg[ADDR_W-1:0];
                            regs_d.oe    = 1'b1;
                            regs_d.state = ST_WADDR_ACK;
                        end else begin
                            mem_we       = ~wp_i;
                            regs_d.ptr   = wr_next;
                            regs_d.oe    = 1'b1;
                            regs_d.state = ST_WDATA_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        if (regs_q.rw) begin
                            rd_load = 1'b1;
                        end else begin
                            regs_d.oe    = 1'b0;
                            regs_d.state = ST_WADDR;
                        end
                    end
                end
                ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        regs_d.oe    = 1'b0;
                        regs_d.state = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (regs_q.cnt == 4'd7) begin
                            regs_d.oe    = 1'b0;
                            regs_d.state = ST_RACK;
                        end else begin
                            regs_d.shreg = {regs_q.shreg[6:0], 1'b0};
                            regs_d.oe    = ~regs_q.shreg[6];
                            regs_d.cnt   = regs_q.cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise)
                        regs_d.more = ~sda_s;
                    if (scl_fall) begin
                        if (regs_q.more)
                            rd_load = 1'b1;
                        else
                            regs_d.state = ST_IDLE;
                    end
                end
                default: ;
            endcase
            if (rd_load) begin
                regs_d.shreg = rdata;
                regs_d.ptr   = rd_next;
                regs_d.oe    = ~rdata[7];
                regs_d.cnt   = '0;
                regs_d.state = ST_RDATA;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q       <= '0;
            regs_q.state <= ST_IDLE;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign sda_oe_o = regs_q.oe;
    assign ptr_q    = regs_q.ptr;
endmodule

// File: rtl/smbt_checker.sv
module smbt_checker #(
    parameter int ADDR_W    = 5,
    parameter int MEM_BYTES = 32,
    parameter int PAGE_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe_o,
    input logic              scl_s,
    input logic              start_ev,
    input logic              stop_ev,
    input logic              scl_rise,
    input logic              scl_fall,
    input logic              mem_we,
    input logic              rd_load,
    input logic [ADDR_W-1:0] ptr_q
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(MEM_BYTES - 1);

    // R4: a stored byte never moves the pointer to another page
    a_r4_write_stays_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])));

    // R3: reading the top byte wraps the pointer to zero
    a_r3_read_wraps_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_load && ptr_q == LAST) |=> (ptr_q == '0));

    // R10: bus conditions release the data line
    a_r10_release_on_condition: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev || stop_ev) |=> !sda_oe_o);

    // R11: the pull-down only moves while the clock line is low, or on release
    a_r11_sda_moves_with_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> (!scl_s || !sda_oe_o));

    // R10: at most one bus event per sample
    a_r10_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_ev, stop_ev, scl_rise, scl_fall}));
endmodule

bind smbt_eeprom_target smbt_checker #(
    .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .PAGE_W(smbt_pkg::PAGE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe_o(sda_oe_o), .scl_s(scl_s),
    .start_ev(start_ev), .stop_ev(stop_ev), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .mem_we(mem_we), .rd_load(rd_load), .ptr_q(ptr_q)
);

// File: tb/smbt_eeprom_target_bench.sv
module smbt_eeprom_target_bench;
    localparam logic [6:0] DEV = 7'h50;
    localparam int         MEM = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1, sda_h = 1'b1, wp = 1'b0;
    logic sda_oe_o, sda_bus;

    int tests = 0, fails = 0;
    logic [7:0] model [MEM];
    int mptr = 0;

    always #4 clk = ~clk;
    assign sda_bus = sda_h & ~sda_oe_o;

    smbt_eeprom_target #(.DEV_ADDR(DEV), .MEM_BYTES(MEM)) u_smbt_eeprom_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus),
        .sda_oe_o(sda_oe_o), .wp_i(wp)
    );

    function automatic int rd_nx(int p); return (p + 1) % MEM; endfunction
    function automatic int wr_nx(int p); return (p & ~7) | ((p + 1) & 7); endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hp(); repeat (5) @(negedge clk); endtask
    task automatic b_start(); sda_h = 1; hp(); scl_h = 1; hp(); sda_h = 0; hp(); scl_h = 0; hp(); endtask
    task automatic b_stop(); sda_h = 0; hp(); scl_h = 1; hp(); sda_h = 1; hp(); endtask
    task automatic wbit(input logic b); sda_h = b; hp(); scl_h = 1; hp(); hp(); scl_h = 0; hp(); endtask
    task automatic rbit(output logic b); sda_h = 1; hp(); scl_h = 1; hp(); b = sda_bus; hp(); scl_h = 0; hp(); endtask

    task automatic wbyte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(ack);
    endtask
    task automatic rbyte(output logic [7:0] v, input logic nack);
        for (int i = 7; i >= 0; i--) rbit(v[i]);
        wbit(nack);
    endtask

    task automatic do_write(input int addr, input int n, input int seed_v);
        logic ack;
        b_start();
        wbyte({DEV, 1'b0}, ack); chk(ack == 0, "R2 dev ack write", ack, 0);
        wbyte(8'(addr), ack);    chk(ack == 0, "R6 waddr ack", ack, 0);
        mptr = addr;
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = 8'(seed_v + i * 37);
            wbyte(d, ack);
            chk(ack == 0, "R9 R8 data ack", ack, 0);
            if (!wp) model[mptr] = d;
            mptr = wr_nx(mptr);
        end
        b_stop();
    endtask

    task automatic read_body(input int n, input string req);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            rbyte(v, i == n - 1);
            chk(v == model[mptr], req, v, model[mptr]);
            mptr = rd_nx(mptr);
        end
        hp();
        chk(sda_oe_o == 0, "R7 released after nack", sda_oe_o, 0);
        b_stop();
    endtask

    task automatic rand_read(input int addr, input int n, input string req);
        logic ack;
        b_start();
        wbyte({DEV, 1'b0}, ack);
        wbyte(8'(addr), ack);
        mptr = addr;
        b_start();
        wbyte({DEV, 1'b1}, ack); chk(ack == 0, "R6 dev ack read", ack, 0);
        read_body(n, req);
    endtask

    task automatic cur_read(input int n, input string req);
        logic ack;
        b_start();
        wbyte({DEV, 1'b1}, ack); chk(ack == 0, "R5 dev ack", ack, 0);
        read_body(n, req);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk); cyc++;
            if (cyc > 150000) begin
                fails++; tests++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        logic ack;
        int r;
        r = $urandom(32'd4711);
        for (int i = 0; i < MEM; i++) model[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1;
        hp();
        chk(sda_oe_o == 0, "R1 line released", sda_oe_o, 0);
        rand_read(0, 3, "R1 reset contents zero");

        // R2: foreign address is not acknowledged
        b_start();
        wbyte({7'h51, 1'b0}, ack);
        chk(ack == 1, "R2 foreign nack", ack, 1);
        wbyte(8'h00, ack);
        chk(ack == 1, "R2 rest ignored", ack, 1);
        b_stop();

        // R6 single byte then random read
        do_write(9, 1, 8'hA5);
        rand_read(9, 1, "R6 random read");
        // R5 current read continues at pointer
        cur_read(2, "R5 current read");

        // R4 R8 page write across offset 7 on the last page
        do_write(29, 12, 8'h11);
        rand_read(24, 8, "R4 R8 page wrap");
        // R3 read roll-over at the array end
        rand_read(30, 4, "R3 read rollover");
        // R5 after write: pointer one past last written byte
        do_write(3, 2, 8'h3C);
        cur_read(1, "R5 after write");

        // R9 write protect
        wp = 1;
        do_write(0, 5, 8'h77);
        wp = 0;
        rand_read(0, 5, "R9 protected bytes unchanged");

        // R10 stop in mid byte: nothing stored, pointer kept
        b_start();
        wbyte({DEV, 1'b0}, ack);
        wbyte(8'd12, ack);
        wbit(1); wbit(1); wbit(0);
        b_stop();
        mptr = 12;
        cur_read(2, "R10 aborted byte not stored");

        // R7 sequential read of several bytes ends on nack
        rand_read(20, 6, "R7 sequential read");

        for (int it = 0; it < 24; it++) begin
            int op, a, n;
            op = $urandom % 3;
            a  = $urandom % MEM;
            n  = 1 + $urandom % 10;
            if (op == 0) begin
                wp = (($urandom % 4) == 0);
                do_write(a, n, int'($urandom % 256));
                wp = 0;
            end else if (op == 1) begin
                rand_read(a, n, "R3 R6 random mix");
            end else begin
                cur_read(1 + n % 5, "R5 random mix");
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule